// File: doc/BRIEF.md
# Up/Down Counter with Command and Sticky Event Status

This block keeps a 32-bit up/down counter together with a lower and an upper boundary register, all reachable through a simple single-cycle register port. Single-cycle count-up and count-down pulses move the counter by one. A strobe from an upstream decoder reports an invalid code, and a marker pulse from an external reference pin can clear the counter once, after software asks for that.

Software steers the block through a command word whose bits trigger one-shot actions when written with one. These actions zero registers, copy the counter into a boundary register, swap the boundaries, or arm the one-time marker clear. Every notable event latches into a sticky status flag that stays set until software writes one to it. A per-flag enable mask combines the pending flags into a single interrupt line.

Top module: `ctr_cmd_status`

## Requirements
- R1: After reset the counter, both boundary registers, the status word, the interrupt enable mask and the marker arm are all zero, and `irq` is low.
- R2: A cycle with `up_pulse` alone adds one to the counter and sets status bit 1. A cycle with `dn_pulse` alone subtracts one and sets status bit 2. Both pulses together, or neither, leave the counter and these flags unchanged.
- R3: A count step that carries or borrows out of counter bit 15 sets status bit 6. A step that carries or borrows out of bit 31 sets status bit 5.
- R4: A count step that leaves the counter at zero sets status bit 7.
- R5: Any counter update, whether a step or a clear, that leaves the counter equal to the lower boundary sets status bit 3. If it leaves the counter equal to the upper boundary, it sets status bit 4.
- R6: Writing the status register (address 3) clears each flag whose data bit is one and leaves the others as they are. If a hardware event sets a flag in the same cycle as a clear, the flag stays set.
- R7: A write to the command register (address 4) acts on each bit written as one. Bit 0 zeroes the counter, bit 1 zeroes the lower boundary and bit 2 zeroes the upper boundary. Addresses 1 and 2 read and write the lower and upper boundary, and address 0 reads the counter.
- R8: Command bit 3 copies the counter into the lower boundary, bit 4 copies it into the upper boundary, and bit 5 swaps the two boundaries. When several bits are written together, the zero actions apply first, then the copies, then the swap.
- R9: Command bit 6 arms the marker clear. Reading address 4 returns 0x40 while the clear is armed and zero otherwise.
- R10: A `zm_pulse` while armed clears the counter, sets status bits 10 and 8, and disarms.
- R11: A `zm_pulse` while not armed sets only status bit 8 and leaves the counter unchanged.
- R12: An armed `zm_pulse` that coincides with a count pulse sets status bit 9. The clear wins, and the step is dropped.
- R13: `irq` is high exactly when some status flag is set and its bit in the enable register (address 5) is one.
- R14: A `bad_code` strobe sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_pulse | input | 1 | Count-up request, one per cycle |
| dn_pulse | input | 1 | Count-down request, one per cycle |
| bad_code | input | 1 | Invalid input code strobe |
| zm_pulse | input | 1 | Reference marker pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| count | output | 32 | Counter value |
| min_val | output | 32 | Lower boundary register |
| max_val | output | 32 | Upper boundary register |
| status | output | 11 | Sticky event flags |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Every internal register of this block is either a port or can be read back, so a wrong value shows one cycle after the edge that produced it. A faulty counter step or clear shows on `count` at once, and within the same edge it also corrupts the boundary-equality and overflow flags. A stale marker arm is only visible through the command readback until the next marker pulse arrives. At that pulse it becomes a counter that clears when it should not, or fails to clear when it should. A flag lost when set and clear collide in the same cycle shows on `status`, and on `irq` when that flag is enabled.

// File: rtl/ctr_cmd_status.sv
module ctr_cmd_status #(
  parameter int CW  = 32,
  parameter int AW  = 3,
  parameter int STW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           up_pulse,
  input  logic           dn_pulse,
  input  logic           bad_code,
  input  logic           zm_pulse,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [CW-1:0]  count,
  output logic [CW-1:0]  min_val,
  output logic [CW-1:0]  max_val,
  output logic [STW-1:0] status,
  output logic           irq
);

  localparam int LO = CW/2 - 1;
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_MAX  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_CMD  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);

  localparam int F_BAD = 0, F_UP = 1, F_DN = 2, F_MIN = 3, F_MAX = 4,
                 F_OVH = 5, F_OVL = 6, F_ZERO = 7, F_ZMP = 8, F_ZME = 9, F_ZMC = 10;

  localparam int C_ZCNT = 0, C_ZMIN = 1, C_ZMAX = 2, C_CMIN = 3,
                 C_CMAX = 4, C_SWAP = 5, C_ARM = 6;

  logic           armed;
  logic [STW-1:0] irq_en;

  logic [CW-1:0]  cnt_n, mn_n, mx_n, tmp;
  logic [STW-1:0] set, clr;

  wire       cmd_wr   = wr_en && wr_addr == A_CMD;
  wire [6:0] cmd      = cmd_wr ? wr_data[6:0] : 7'd0;
  wire       zm_clr   = zm_pulse && armed;
  wire       zero_cnt = cmd[C_ZCNT] || zm_clr;
  wire       up_s     = up_pulse && !dn_pulse && !zero_cnt;
  wire       dn_s     = dn_pulse && !up_pulse && !zero_cnt;
  wire       upd      = up_s || dn_s || zero_cnt;

  always_comb begin
    cnt_n = count;
    if (zero_cnt)  cnt_n = '0;
    else if (up_s) cnt_n = count + CW'(1);
    else if (dn_s) cnt_n = count - CW'(1);

    mn_n = (wr_en && wr_addr == A_MIN) ? wr_data : min_val;
    mx_n = (wr_en && wr_addr == A_MAX) ? wr_data : max_val;
    if (cmd[C_ZMIN]) mn_n = '0;
    if (cmd[C_ZMAX]) mx_n = '0;
    if (cmd[C_CMIN]) mn_n = cnt_n;
    if (cmd[C_CMAX]) mx_n = cnt_n;
    tmp = mn_n;
    if (cmd[C_SWAP]) begin
      mn_n = mx_n;
      mx_n = tmp;
    end
  end

  always_comb begin
    set        = '0;
    set[F_BAD] = bad_code;
    set[F_UP]  = up_s;
    set[F_DN]  = dn_s;
    set[F_OVL] = (up_s && &count[LO:0]) || (dn_s && ~|count[LO:0]);
    set[F_OVH] = (up_s && &count) || (dn_s && ~|count);
    set[F_ZERO]= (up_s || dn_s) && cnt_n == '0;
    set[F_MIN] = upd && cnt_n == mn_n;
    set[F_MAX] = upd && cnt_n == mx_n;
    set[F_ZMP] = zm_pulse;
    set[F_ZMC] = zm_clr;
    set[F_ZME] = zm_clr && (up_pulse || dn_pulse);
    clr        = (wr_en && wr_addr == A_STAT) ? wr_data[STW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      min_val <= '0;
      max_val <= '0;
      status  <= '0;
      armed   <= 1'b0;
      irq_en  <= '0;
    end else begin
      count   <= cnt_n;
      min_val <= mn_n;
      max_val <= mx_n;
      status  <= (status & ~clr) | set;
      armed   <= cmd[C_ARM] || (armed && !zm_pulse);
      if (wr_en && wr_addr == A_IEN) irq_en <= wr_data[STW-1:0];
    end
  end

  assign irq = |(status & irq_en);

  always_comb begin
    case (rd_addr)
      A_CNT:   rd_data = count;
      A_MIN:   rd_data = min_val;
      A_MAX:   rd_data = max_val;
      A_STAT:  rd_data = CW'(status);
      A_CMD:   rd_data = CW'({armed, 6'd0});
      A_IEN:   rd_data = CW'(irq_en);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ctr_cmd_status_chk.sv
module ctr_cmd_status_chk #(
  parameter int CW  = 32,
  parameter int AW  = 3,
  parameter int STW = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           up_pulse,
  input logic           dn_pulse,
  input logic           zm_pulse,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [CW-1:0]  wr_data,
  input logic [CW-1:0]  count,
  input logic [CW-1:0]  min_val,
  input logic [CW-1:0]  max_val,
  input logic [STW-1:0] status,
  input logic           irq,
  input logic           armed
);

  wire cmd_wr  = wr_en && wr_addr == AW'(4);
  wire quiet   = !(cmd_wr && wr_data[0]) && !(zm_pulse && armed);
  wire swap_only = cmd_wr && wr_data[6:0] == 7'b0100000;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && !dn_pulse && quiet) |=> count == $past(count) + CW'(1));

  assert_step_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_pulse && !up_pulse && quiet) |=> count == $past(count) - CW'(1));

  assert_cmd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[0]) |=> count == '0);

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_only |=> (min_val == $past(max_val) && max_val == $past(min_val)));

  assert_armed_marker_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zm_pulse && armed) |=> (count == '0 && status[10] && status[8]));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(3)) |=> (status & $past(status)) == $past(status));

  assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    status == '0 |-> !irq);

endmodule

bind ctr_cmd_status ctr_cmd_status_chk #(.CW(CW), .AW(AW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
  .zm_pulse(zm_pulse), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count(count), .min_val(min_val), .max_val(max_val), .status(status),
  .irq(irq), .armed(armed)
);

// File: tb/ctr_cmd_status_bench.sv
module ctr_cmd_status_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        up_pulse = 0, dn_pulse = 0, bad_code = 0, zm_pulse = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, count, min_val, max_val;
  logic [10:0] status;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ctr_cmd_status u_ctr_cmd_status (
    .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .bad_code(bad_code), .zm_pulse(zm_pulse), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .count(count),
    .min_val(min_val), .max_val(max_val), .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic hold_up(int n);
    @(negedge clk); up_pulse = 1;
    repeat (n) @(negedge clk);
    up_pulse = 0;
  endtask

  task automatic hold_dn(int n);
    @(negedge clk); dn_pulse = 1;
    repeat (n) @(negedge clk);
    dn_pulse = 0;
  endtask

  task automatic clr_all();
    wr(3'd3, 32'h7FF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 count", count, 0);
    chk("R1 min", min_val, 0);
    chk("R1 max", max_val, 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd4, d); chk("R1 arm readback", d, 0);
    rd(3'd5, d); chk("R1 enable", d, 0);
  endtask

  task automatic t_count();
    hold_up(3);
    chk("R2 up count", count, 3);
    chk("R2 up flag", 32'(status[1]), 1);
    chk("R2 no down flag", 32'(status[2]), 0);
    clr_all();
    @(negedge clk); up_pulse = 1; dn_pulse = 1;
    @(negedge clk); up_pulse = 0; dn_pulse = 0;
    chk("R2 both hold", count, 3);
    chk("R2 both no flags", 32'(status[2:1]), 0);
    hold_dn(3);
    chk("R2 down count", count, 0);
    chk("R2 down flag", 32'(status[2]), 1);
    chk("R4 zero flag", 32'(status[7]), 1);
  endtask

  task automatic t_wrap();
    clr_all();
    hold_dn(1);
    chk("R3 borrow count", count, 32'hFFFF_FFFF);
    chk("R3 borrow bit31", 32'(status[5]), 1);
    chk("R3 borrow bit15", 32'(status[6]), 1);
    clr_all();
    hold_up(1);
    chk("R3 carry count", count, 0);
    chk("R3 carry bit31", 32'(status[5]), 1);
    chk("R4 zero on wrap", 32'(status[7]), 1);
    clr_all();
    hold_up(65535);
    chk("R3 below carry", count, 32'h0000_FFFF);
    chk("R3 no bit15 yet", 32'(status[6]), 0);
    hold_up(1);
    chk("R3 carry 15 count", count, 32'h0001_0000);
    chk("R3 bit15 only", 32'(status[6:5]), 2);
    wr(3'd4, 32'h1);
    chk("R7 zero counter", count, 0);
    clr_all();
  endtask

  task automatic t_bounds();
    logic [31:0] d;
    wr(3'd1, 2); wr(3'd2, 4);
    clr_all();
    hold_up(2);
    chk("R5 min hit", 32'(status[3]), 1);
    chk("R5 max not hit", 32'(status[4]), 0);
    hold_up(2);
    chk("R5 max hit", 32'(status[4]), 1);
    rd(3'd1, d); chk("R7 min readback", d, 2);
    rd(3'd0, d); chk("R7 count readback", d, 4);
  endtask

  task automatic t_cmds();
    wr(3'd4, 32'h08);
    chk("R8 capture min", min_val, 4);
    wr(3'd1, 9);
    wr(3'd4, 32'h20);
    chk("R8 swap min", min_val, 4);
    chk("R8 swap max", max_val, 9);
    wr(3'd4, 32'h10);
    chk("R8 capture max", max_val, 4);
    wr(3'd1, 1);
    wr(3'd4, 32'h0A);
    chk("R8 zero then capture", min_val, 4);
    wr(3'd2, 7);
    wr(3'd4, 32'h28);
    chk("R8 capture then swap min", min_val, 7);
    chk("R8 capture then swap max", max_val, 4);
    wr(3'd4, 32'h09);
    chk("R8 zero count before capture", min_val, 0);
    chk("R7 zero count", count, 0);
    wr(3'd4, 32'h04);
    chk("R7 zero max", max_val, 0);
    wr(3'd1, 5);
    wr(3'd4, 32'h02);
    chk("R7 zero min", min_val, 0);
  endtask

  task automatic t_w1c();
    clr_all();
    hold_up(1);
    @(negedge clk); bad_code = 1;
    @(negedge clk); bad_code = 0;
    chk("R14 bad code flag", 32'(status[0]), 1);
    wr(3'd3, 32'h2);
    chk("R6 cleared bit", 32'(status[1]), 0);
    chk("R6 other kept", 32'(status[0]), 1);
    @(negedge clk); up_pulse = 1; wr_en = 1; wr_addr = 3'd3; wr_data = 32'h2;
    @(negedge clk); up_pulse = 0; wr_en = 0;
    chk("R6 set wins", 32'(status[1]), 1);
    chk("R6 count stepped", count, 2);
  endtask

  task automatic t_zm();
    logic [31:0] d;
    clr_all();
    @(negedge clk); zm_pulse = 1;
    @(negedge clk); zm_pulse = 0;
    chk("R11 unarmed count", count, 2);
    chk("R11 pin flag only", 32'(status), 32'h100);
    clr_all();
    wr(3'd4, 32'h40);
    rd(3'd4, d); chk("R9 armed readback", d, 32'h40);
    @(negedge clk); zm_pulse = 1;
    @(negedge clk); zm_pulse = 0;
    chk("R10 cleared", count, 0);
    chk("R10 zeroed flag", 32'(status[10]), 1);
    chk("R10 pin flag", 32'(status[8]), 1);
    chk("R12 no error", 32'(status[9]), 0);
    rd(3'd4, d); chk("R9 disarmed readback", d, 0);
    hold_up(3);
    clr_all();
    wr(3'd4, 32'h40);
    @(negedge clk); zm_pulse = 1; up_pulse = 1;
    @(negedge clk); zm_pulse = 0; up_pulse = 0;
    chk("R12 clear wins", count, 0);
    chk("R12 error flag", 32'(status[9]), 1);
    chk("R12 step dropped", 32'(status[1]), 0);
  endtask

  task automatic t_irq();
    clr_all();
    wr(3'd5, 32'h2);
    chk("R13 idle", 32'(irq), 0);
    hold_up(1);
    chk("R13 raised", 32'(irq), 1);
    wr(3'd5, 32'h0);
    chk("R13 masked", 32'(irq), 0);
    wr(3'd5, 32'h2);
    chk("R13 unmasked", 32'(irq), 1);
    wr(3'd3, 32'h2);
    chk("R13 cleared", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_bounds();
    t_cmds();
    t_w1c();
    t_zm();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule